// File: doc/BRIEF.md
# TDM Slot Schedule Generator

This block builds the time-slot table that a time-division memory arbiter uses to share a memory between 14 clients. There are two regions, external (region 0) and internal (region 1), and each has its own 64-slot table. A client asks for bandwidth in one region. The block turns that bandwidth into a slot count and decides whether to accept the request. On acceptance it rebuilds that region's table and streams the result, one slot per cycle, to the runtime arbiter's table write port.

The table is built in two passes. In the first pass, clients that hold reserved slots are placed in ascending client order. Each one starts at slot 0 and is then spaced at a fixed interval; when a slot is already taken, the position moves forward by one. In the second pass, every slot that is still free goes to the active clients in round-robin order. Requests arrive as single-cycle strobes while the block is idle. Each request ends in exactly one of three single-cycle pulses: done, reject or error.

Top module: `tdm_slot_sched`

## Requirements
- R1: After reset the block is idle: busy, done, reject, error and write enable are all low. Clients 10 and 11 are active in region 0 with zero reserved slots, and no client is active in region 1.
- R2: An accepted request of bandwidth B in a region with maximum M (100,000,000 for region 0, 400,000,000 for region 1) sets the client's reserved count to N = 64 / (M / B), using integer division at both steps, and marks the client active.
- R3: Placement pass: all slots begin free. Each client with N > 0 is placed in ascending index order with step 64/N, starting at position 0. An occupied position advances by one. A free position takes the client and then advances by the step. Placement for that client stops once the position is 64 or more.
- R4: Fill pass: each slot still free, in ascending order, takes the first active client found from a round-robin pointer. The pointer starts at 0 for every rebuild, searches upward modulo 14, and after each fill moves to one past the chosen client.
- R5: A request is rejected with a one-cycle reject pulse when the region's summed reserved counts, plus its active-client count, plus N, plus 1 exceed 64. A rejected request writes nothing and changes no state.
- R6: A request with zero bandwidth, with a bandwidth above the region maximum (ratio zero), or with a client index of 14 or 15 gives a one-cycle error pulse. It writes nothing and changes no state.
- R7: A rebuild emits exactly 64 writes on consecutive cycles, with slot indices 0 to 63 in ascending order. Every client value written is below 14.
- R8: Busy is high from the cycle after an accepted strobe until the done pulse. Done lasts one cycle, comes the cycle after the last write, and busy falls right after it. A strobe that arrives while busy is ignored.
- R9: Each write carries the region of the request that caused it. A request in one region leaves the other region's schedule unchanged.
- R10: A new accepted request from a client that already holds slots replaces that client's reserved count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, sampled only while idle |
| req_region_i | input | 1 | Region of request (0 external, 1 internal) |
| req_client_i | input | 4 | Requesting client index |
| req_bw_i | input | 32 | Requested bandwidth |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse: table rebuilt |
| rej_o | output | 1 | One-cycle pulse: admission refused |
| err_o | output | 1 | One-cycle pulse: invalid request |
| wr_en_o | output | 1 | Table write strobe |
| wr_region_o | output | 1 | Region of table being written |
| wr_slot_o | output | 6 | Slot index written |
| wr_client_o | output | 4 | Client assigned to that slot |

## Verification
The assertions check the following on every cycle: the write stream advances one slot at a time, never writes the free marker, and only writes while busy. They also check that done, reject and error never coincide, that done is a single-cycle pulse raised while busy, and that the fill pass always picks an active client when one exists. Only the bench scenarios can show that the table contents are correct. That covers interval placement with collisions pushed forward, the round-robin fill order, the reserved-count arithmetic and the admission limit. The bench also shows that rejected, erroneous and mid-rebuild requests leave later schedules unchanged.

// File: rtl/tdm_sched_pkg.sv
package tdm_sched_pkg;
  localparam int NCLI    = 14;
  localparam int NSLOT   = 64;
  localparam int NREG    = 2;
  localparam int CW      = $clog2(NCLI + 2);
  localparam int SW      = $clog2(NSLOT);
  localparam int NW      = SW + 1;
  localparam int DW      = 32;
  localparam int TW      = $clog2(NCLI * (NSLOT + 1) + NSLOT + 2) + 1;

  typedef logic [CW-1:0] cli_t;
  typedef logic [NW-1:0] cnt_t;

  localparam cli_t FREE_ID = cli_t'(NCLI + 1);
endpackage

// File: rtl/tdm_div.sv
module tdm_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int KW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q, den_q;
  logic [KW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    trial;

  assign trial = {rem_q[W-1:0], quo_q[W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; quo_q <= '0; den_q <= '0; cnt_q <= '0;
      run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q <= '0; quo_q <= num_i; den_q <= den_i;
        cnt_q <= KW'(W); run_q <= 1'b1;
      end else if (run_q) begin
        if (trial >= {1'b0, den_q}) begin
          rem_q <= trial - {1'b0, den_q};
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= trial;
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == KW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;

  a_r2_div_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/tdm_fill_engine.sv
module tdm_fill_engine
  import tdm_sched_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [NCLI-1:0][NW-1:0]  cnt_i,
  input  logic [NCLI-1:0][NW-1:0]  step_i,
  input  logic [NCLI-1:0]          act_i,
  output logic                     wr_en_o,
  output logic [SW-1:0]            wr_slot_o,
  output cli_t                     wr_client_o,
  output logic                     done_o
);
  typedef enum logic [1:0] {E_IDLE, E_PLACE, E_FILL} est_t;

  est_t          st_q;
  cli_t          tab_q [NSLOT];
  cli_t          cli_q, rr_q, pick, rr_nxt;
  cnt_t          pos_q;
  logic [SW-1:0] slot_q;
  logic          wr_en_q, done_q;
  logic [SW-1:0] wr_slot_q;
  cli_t          wr_cli_q;
  logic [SW-1:0] pslot;

  assign pslot = pos_q[SW-1:0];

  // first active client at or after rr, wrapping; rr itself if none
  always_comb begin
    logic found;
    pick  = rr_q;
    found = 1'b0;
    for (int k = 0; k < NCLI; k++) begin
      int idx;
      idx = int'(rr_q) + k;
      if (idx >= NCLI) idx = idx - NCLI;
      if (!found && act_i[idx]) begin
        pick  = cli_t'(idx);
        found = 1'b1;
      end
    end
    rr_nxt = (pick == cli_t'(NCLI - 1)) ? '0 : pick + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= E_IDLE;
      for (int i = 0; i < NSLOT; i++) tab_q[i] <= FREE_ID;
      cli_q <= '0; rr_q <= '0; pos_q <= '0; slot_q <= '0;
      wr_en_q <= 1'b0; wr_slot_q <= '0; wr_cli_q <= '0; done_q <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      done_q  <= wr_en_q && (wr_slot_q == SW'(NSLOT - 1));
      unique case (st_q)
        E_IDLE: if (start_i) begin
          for (int i = 0; i < NSLOT; i++) tab_q[i] <= FREE_ID;
          cli_q <= '0;
          pos_q <= '0;
          st_q  <= E_PLACE;
        end
        E_PLACE: begin
          if (cli_q == cli_t'(NCLI)) begin
            st_q   <= E_FILL;
            slot_q <= '0;
            rr_q   <= '0;
          end else if (cnt_i[cli_q] == '0 || pos_q >= cnt_t'(NSLOT)) begin
            cli_q <= cli_q + 1'b1;
            pos_q <= '0;
          end else if (tab_q[pslot] != FREE_ID) begin
            pos_q <= pos_q + 1'b1;
          end else begin
            tab_q[pslot] <= cli_q;
            pos_q        <= pos_q + step_i[cli_q];
          end
        end
        E_FILL: begin
          wr_en_q   <= 1'b1;
          wr_slot_q <= slot_q;
          if (tab_q[slot_q] == FREE_ID) begin
            wr_cli_q <= pick;
            rr_q     <= rr_nxt;
          end else begin
            wr_cli_q <= tab_q[slot_q];
          end
          slot_q <= slot_q + 1'b1;
          if (slot_q == SW'(NSLOT - 1)) st_q <= E_IDLE;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign wr_en_o     = wr_en_q;
  assign wr_slot_o   = wr_slot_q;
  assign wr_client_o = wr_cli_q;
  assign done_o      = done_q;

  a_r7_slot_ascend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_slot_o != SW'(NSLOT - 1)) |=> (wr_en_o && wr_slot_o == $past(wr_slot_o) + 1'b1));
  a_r7_client_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_client_o < cli_t'(NCLI)));
  a_r4_pick_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == E_FILL && tab_q[slot_q] == FREE_ID && |act_i) |=> act_i[wr_client_o]);
  a_r3_place_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == E_PLACE && $past(st_q) == E_PLACE) |-> cli_q >= $past(cli_q));
endmodule

// File: rtl/tdm_slot_sched.sv
module tdm_slot_sched
  import tdm_sched_pkg::*;
#(
  parameter int unsigned EXT_MAX_BW = 100_000_000,
  parameter int unsigned INT_MAX_BW = 400_000_000,
  parameter logic [NCLI-1:0] EXT_BOOT_ACT = NCLI'(14'h0C00)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_region_i,
  input  logic [3:0]  req_client_i,
  input  logic [31:0] req_bw_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        rej_o,
  output logic        err_o,
  output logic        wr_en_o,
  output logic        wr_region_o,
  output logic [5:0]  wr_slot_o,
  output logic [3:0]  wr_client_o
);
  typedef enum logic [2:0] {T_IDLE, T_D1, T_D2, T_D3, T_COMMIT, T_RUN} tst_t;

  tst_t                     st_q;
  logic [NCLI-1:0][NW-1:0]  cnt_q  [NREG];
  logic [NCLI-1:0][NW-1:0]  step_q [NREG];
  logic [NCLI-1:0]          act_q  [NREG];
  logic                     rgn_q;
  cli_t                     cli_q;
  cnt_t                     n_q, stp_q;
  logic [DW-1:0]            num_q, den_q, quot;
  logic                     go_q, div_done, eng_go_q, eng_done;
  logic                     err_q, rej_q;
  logic [TW-1:0]            used;
  logic [DW-1:0]            rmax;

  assign rmax = req_region_i ? INT_MAX_BW : EXT_MAX_BW;

  // slots already committed in the region: reserved counts plus active clients
  always_comb begin
    used = '0;
    for (int c = 0; c < NCLI; c++)
      used = used + TW'(cnt_q[rgn_q][c]) + TW'(act_q[rgn_q][c]);
  end

  tdm_div #(.W(DW)) u_div (
    .clk_i, .rst_ni, .start_i(go_q), .num_i(num_q), .den_i(den_q),
    .done_o(div_done), .quot_o(quot)
  );

  tdm_fill_engine u_eng (
    .clk_i, .rst_ni, .start_i(eng_go_q),
    .cnt_i(cnt_q[rgn_q]), .step_i(step_q[rgn_q]), .act_i(act_q[rgn_q]),
    .wr_en_o, .wr_slot_o, .wr_client_o, .done_o(eng_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= T_IDLE;
      for (int r = 0; r < NREG; r++) begin
        cnt_q[r] <= '0; step_q[r] <= '0;
        act_q[r] <= (r == 0) ? EXT_BOOT_ACT : '0;
      end
      rgn_q <= 1'b0; cli_q <= '0; n_q <= '0; stp_q <= '0;
      num_q <= '0; den_q <= '0; go_q <= 1'b0; eng_go_q <= 1'b0;
      err_q <= 1'b0; rej_q <= 1'b0;
    end else begin
      go_q <= 1'b0; eng_go_q <= 1'b0; err_q <= 1'b0; rej_q <= 1'b0;
      unique case (st_q)
        T_IDLE: if (req_valid_i) begin
          if (req_bw_i == '0 || req_client_i >= 4'(NCLI)) begin
            err_q <= 1'b1;
          end else begin
            rgn_q <= req_region_i;
            cli_q <= cli_t'(req_client_i);
            num_q <= rmax;
            den_q <= req_bw_i;
            go_q  <= 1'b1;
            st_q  <= T_D1;
          end
        end
        T_D1: if (div_done) begin
          if (quot == '0) begin
            err_q <= 1'b1;
            st_q  <= T_IDLE;
          end else begin
            num_q <= DW'(NSLOT);
            den_q <= quot;
            go_q  <= 1'b1;
            st_q  <= T_D2;
          end
        end
        T_D2: if (div_done) begin
          if (DW'(used) + quot + 1 > DW'(NSLOT)) begin
            rej_q <= 1'b1;
            st_q  <= T_IDLE;
          end else begin
            n_q <= quot[NW-1:0];
            if (quot == '0) begin
              stp_q <= '0;
              st_q  <= T_COMMIT;
            end else begin
              num_q <= DW'(NSLOT);
              den_q <= quot;
              go_q  <= 1'b1;
              st_q  <= T_D3;
            end
          end
        end
        T_D3: if (div_done) begin
          stp_q <= quot[NW-1:0];
          st_q  <= T_COMMIT;
        end
        T_COMMIT: begin
          cnt_q[rgn_q][cli_q]  <= n_q;
          step_q[rgn_q][cli_q] <= stp_q;
          act_q[rgn_q][cli_q]  <= 1'b1;
          eng_go_q <= 1'b1;
          st_q     <= T_RUN;
        end
        T_RUN: if (eng_done) st_q <= T_IDLE;
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != T_IDLE);
  assign done_o      = (st_q == T_RUN) && eng_done;
  assign rej_o       = rej_q;
  assign err_o       = err_q;
  assign wr_region_o = rgn_q;

  a_r8_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  a_r8_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);
  a_r5_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, rej_o, err_o}));
  a_r6_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o || rej_o) |-> (!wr_en_o && !busy_o));
  a_r9_region_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> $stable(wr_region_o));
endmodule

// File: tb/tb_tdm_slot_sched.sv
`timescale 1ns/1ps
module tb_tdm_slot_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_region = 1'b0;
  logic [3:0]  req_client = '0;
  logic [31:0] req_bw = '0;
  logic        busy, done, rej, err, wr_en, wr_region;
  logic [5:0]  wr_slot;
  logic [3:0]  wr_client;

  always #2 clk = ~clk;

  tdm_slot_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_region_i(req_region),
    .req_client_i(req_client), .req_bw_i(req_bw), .busy_o(busy), .done_o(done),
    .rej_o(rej), .err_o(err), .wr_en_o(wr_en), .wr_region_o(wr_region),
    .wr_slot_o(wr_slot), .wr_client_o(wr_client)
  );

  int checks = 0, fails = 0;
  int mreq [2][14];
  bit mact [2][14];
  int etab [64];
  int gtab [64];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void build(int rg);
    int rr;
    for (int s = 0; s < 64; s++) etab[s] = 15;
    for (int c = 0; c < 14; c++) begin
      int pos, stp;
      if (mreq[rg][c] == 0) continue;
      stp = 64 / mreq[rg][c];
      pos = 0;
      while (pos < 64) begin
        if (etab[pos] != 15) pos++;
        else begin etab[pos] = c; pos += stp; end
      end
    end
    rr = 0;
    for (int s = 0; s < 64; s++) begin
      if (etab[s] == 15) begin
        int first;
        first = rr;
        while (!mact[rg][rr]) begin
          rr = (rr + 1) % 14;
          if (rr == first) break;
        end
        etab[s] = rr;
        rr = (rr + 1) % 14;
      end
    end
  endfunction

  task automatic do_req(int rg, int cl, int unsigned bw, bit poke);
    int unsigned mx, ratio;
    int n, tot, kind, got, cyc, gcnt;
    bit seq_ok, rg_ok;
    mx = (rg != 0) ? 32'd400000000 : 32'd100000000;
    kind = 0; n = 0;
    if (bw == 0 || cl >= 14) kind = 2;
    else begin
      ratio = mx / bw;
      if (ratio == 0) kind = 2;
      else begin
        n = 64 / int'(ratio);
        tot = 0;
        for (int c = 0; c < 14; c++) tot += mreq[rg][c] + int'(mact[rg][c]);
        if (tot + n + 1 > 64) kind = 1;
      end
    end
    if (kind == 0) begin
      mreq[rg][cl] = n;
      mact[rg][cl] = 1'b1;
      build(rg);
    end
    req_valid = 1'b1; req_region = rg[0]; req_client = cl[3:0]; req_bw = bw;
    @(negedge clk);
    req_valid = 1'b0;
    got = -1; gcnt = 0; seq_ok = 1'b1; rg_ok = 1'b1; cyc = 0;
    while (got < 0 && cyc < 4000) begin
      if (wr_en) begin
        if (gcnt < 64) gtab[gcnt] = int'(wr_client);
        if (int'(wr_slot) != gcnt || !busy) seq_ok = 1'b0;
        if (int'(wr_region) != rg) rg_ok = 1'b0;
        gcnt++;
      end
      if (done) got = 0; else if (rej) got = 1; else if (err) got = 2;
      // strobe during rebuild must be ignored (R8)
      if (poke && cyc == 10) begin
        req_valid = 1'b1; req_client = 4'd7; req_bw = mx / 2;
      end
      if (poke && cyc == 11) req_valid = 1'b0;
      if (got < 0) begin @(negedge clk); cyc++; end
    end
    chk(got == kind, (kind == 1) ? "R5 reject outcome" : (kind == 2) ? "R6 error outcome" : "R2 R8 accept outcome", got, kind);
    if (kind == 0) begin
      chk(gcnt == 64, "R7 write count", gcnt, 64);
      chk(seq_ok, "R7 R8 consecutive ascending writes while busy", int'(seq_ok), 1);
      chk(rg_ok, "R9 write region tag", int'(rg_ok), 1);
      for (int s = 0; s < 64; s++)
        chk(gtab[s] == etab[s], $sformatf("R2 R3 R4 R10 region %0d slot %0d", rg, s), gtab[s], etab[s]);
      @(negedge clk);
      chk(!busy && !done, "R8 idle after done", int'(busy), 0);
    end else begin
      chk(gcnt == 0, "R5 R6 no write on refusal", gcnt, 0);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 14; c++) begin mreq[r][c] = 0; mact[r][c] = 1'b0; end
    mact[0][10] = 1'b1; mact[0][11] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wr_en && !done && !rej && !err, "R1 idle after reset", int'(busy), 0);

    do_req(0, 3, 32'd25000000, 1'b0);   // R1 boot actives fill; R3 step 4
    do_req(0, 0, 32'd10000000, 1'b1);   // R3 collision shift; R8 ignored strobe
    do_req(1, 5, 32'd400000000, 1'b0);  // R5 n=64 refused
    do_req(0, 4, 32'd0, 1'b0);          // R6 zero bandwidth
    do_req(0, 4, 32'd150000000, 1'b0);  // R6 ratio zero
    do_req(1, 14, 32'd1000000, 1'b0);   // R6 bad client
    do_req(1, 2, 32'd1000000, 1'b0);    // R4 n=0, only active client fills; R9
    do_req(0, 3, 32'd50000000, 1'b0);   // R10 replace count
    do_req(1, 9, 32'd50000000, 1'b0);   // R4 fill rotates 2 and 9
    do_req(0, 6, 32'd100000000, 1'b0);  // R5 n=64 refused

    void'($urandom(32'd1234));
    for (int i = 0; i < 30; i++) begin
      int rg, cl;
      int unsigned bw, mx;
      rg = int'($urandom_range(0, 1));
      cl = int'($urandom_range(0, 15));
      mx = (rg != 0) ? 32'd400000000 : 32'd100000000;
      if ($urandom_range(0, 9) == 0) bw = $urandom_range(0, 2);
      else bw = mx / $urandom_range(1, 90);
      do_req(rg, cl, bw, (i % 4) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule